// File: doc/BRIEF.md
# Work-Group Dispatcher with Per-Core Residency Caps

The block hands out the thread groups of one running kernel to a set of cores. A kernel is started with its total group count and a hardware ceiling on how many groups a core may hold at once. The group IDs run from zero upward, and the block offers one group at a time to one core through a valid/ready handshake. Each core has a residency cap of its own. At kernel start every cap is set to half the ceiling, rounded down, but never less than one. A per-core controller may rewrite its cap at any time while the kernel runs. A lowered cap evicts nothing: it only stops refills until enough of that core's groups have finished.

The block keeps a resident count for each core. The count goes up by one when the core accepts an offer and down by one when the core pulses that a group has finished. A core may receive work only while its count is below its cap. When several cores qualify, a rotating pointer serves the first one after the core served last. With equal caps this fills the cores in strict passes, so that no core gets a second group before every core has its first. When all groups have been handed out and every core has drained to zero, a kernel-complete flag rises.

Top module: `wgd_dispatch`

## Requirements
- R1: After reset, no issue_valid bit is high and kernel_done is low.
- R2: A start pulse is taken only while no kernel is running. It latches the group count and the ceiling (0 is read as 1, above 8 is read as 8) and sets every cap to max(1, floor(ceiling/2)). A start while a kernel runs changes nothing.
- R3: Group IDs are offered in increasing order from 0 to count-1, and each one is accepted exactly once.
- R4: A core is offered a group only while its resident count (accepted minus finished) is below its cap. A completion pulse lowers the count by one.
- R5: The offered core is the first eligible core at or after the core following the one served last. The pointer starts at core 0 on each kernel start. With equal caps and no completions, the resident counts of any two cores never differ by more than 1.
- R6: At most one issue_valid bit is high. An offer keeps its core and issue_gid unchanged until that core's issue_ready is high.
- R7: A cap write, with the value in lim_val slice [4c+3:4c] for core c, takes effect only if the value lies in 1..ceiling. Any other value is ignored.
- R8: Lowering a cap below a core's resident count evicts nothing. That core is offered no new group until its count falls below the new cap.
- R9: kernel_done rises once every group has been accepted and every resident count is zero, including a kernel of zero groups. A taken start clears it, and no offer is made while it is high.
- R10: A core's resident count never exceeds the ceiling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Kernel start pulse |
| total_groups | input | 16 | Number of groups in the kernel, sampled on start |
| hw_max | input | 4 | Per-core residency ceiling, sampled on start |
| lim_wr | input | 4 | Per-core cap write strobe |
| lim_val | input | 16 | Per-core cap values, 4 bits per core |
| done_pulse | input | 4 | Per-core group-finished pulse |
| issue_ready | input | 4 | Per-core acceptance of an offer |
| issue_valid | output | 4 | Per-core offer strobe, at most one high |
| issue_gid | output | 16 | Group ID of the current offer |
| kernel_done | output | 1 | All groups issued and all cores drained |

## Verification
The assertions assume that a core pulses completion only while it holds at least one resident group. The bench keeps to this by masking every completion pulse with its own count of accepted and unfinished groups per core. The assertions also assume that a kernel is not started while the previous one still has groups in flight. The random phase draws its cap writes from 0 to 9, so it drives values that are in range and values that are out of range. Completions and ready are random, and the bench waits for kernel_done before it starts the next kernel.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
  localparam int unsigned MAX_RES = 8;
  localparam int unsigned RES_W   = $clog2(MAX_RES + 1);

  typedef logic [RES_W-1:0] res_t;

  // Start-of-kernel cap: half the ceiling, never below one.
  function automatic res_t start_cap(res_t ceil_v);
    res_t half;
    half = ceil_v >> 1;
    return (half == '0) ? res_t'(1) : half;
  endfunction
endpackage

// File: rtl/wgd_rr_pick.sv
module wgd_rr_pick #(
  parameter int unsigned N = 4,
  localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] ptr,
  output logic          any,
  output logic [IW-1:0] idx
);
  localparam int NC = N;

  // Scan downward so that the lowest offset from ptr wins.
  always_comb begin
    int c;
    any = 1'b0;
    idx = '0;
    for (int k = NC - 1; k >= 0; k--) begin
      c = (int'(ptr) + k) % NC;
      if (req[c]) begin
        any = 1'b1;
        idx = IW'(c);
      end
    end
  end
endmodule

// File: rtl/wgd_core_slot.sv
module wgd_core_slot
  import wgd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic kick,
  input  res_t kick_cap,
  input  res_t ceil_q,
  input  logic lim_wr,
  input  res_t lim_val,
  input  logic accept,
  input  logic done,
  output logic eligible,
  output logic idle
);
  res_t cap_q, cap_d, res_q, res_d;
  logic cap_ok, cap_en, res_en, done_eff;

  always_comb begin
    cap_ok   = lim_wr && (lim_val != '0) && (lim_val <= ceil_q);
    cap_en   = kick || cap_ok;
    cap_d    = kick ? kick_cap : lim_val;
    done_eff = done && (res_q != '0);
    res_en   = kick || accept || done_eff;
    res_d    = kick ? '0 : (res_q + res_t'(accept) - res_t'(done_eff));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q <= res_t'(1);
      res_q <= '0;
    end else begin
      if (cap_en) cap_q <= cap_d;
      if (res_en) res_q <= res_d;
    end
  end

  assign eligible = (res_q < cap_q);
  assign idle     = (res_q == '0);

  assert_cap_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_q != '0) && (cap_q <= ceil_q));

  assert_res_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    res_q <= ceil_q);

  // Input rule: a completion only comes from a core holding a group.
  assert_done_has_group_R4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_q != '0));
endmodule

// File: rtl/wgd_dispatch.sv
module wgd_dispatch
  import wgd_pkg::*;
#(
  parameter int unsigned NUM_CORES = 4,
  parameter int unsigned GID_W     = 16,
  localparam int unsigned IW = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [GID_W-1:0]             total_groups,
  input  logic [RES_W-1:0]             hw_max,
  input  logic [NUM_CORES-1:0]         lim_wr,
  input  logic [NUM_CORES*RES_W-1:0]   lim_val,
  input  logic [NUM_CORES-1:0]         done_pulse,
  input  logic [NUM_CORES-1:0]         issue_ready,
  output logic [NUM_CORES-1:0]         issue_valid,
  output logic [GID_W-1:0]             issue_gid,
  output logic                         kernel_done
);
  logic             active_q, active_d;
  logic             pend_q, pend_d;
  logic             kdone_q, kdone_d;
  logic [GID_W-1:0] total_q, total_d;
  logic [GID_W-1:0] next_q, next_d;
  logic [GID_W-1:0] pgid_q, pgid_d;
  logic [IW-1:0]    pcore_q, pcore_d;
  logic [IW-1:0]    ptr_q, ptr_d;
  res_t             ceil_q, ceil_d;
  res_t             kick_ceil, kick_cap;

  logic                 kick, fire, can_pick, drained;
  logic                 pick_any;
  logic [IW-1:0]        pick_idx;
  logic [NUM_CORES-1:0] eligible, idle, accept;

  wgd_rr_pick #(.N(NUM_CORES)) picker_i (
    .req (eligible),
    .ptr (ptr_q),
    .any (pick_any),
    .idx (pick_idx)
  );

  generate
    for (genvar c = 0; c < NUM_CORES; c++) begin : g_slot
      assign accept[c]      = fire && (pcore_q == IW'(c));
      assign issue_valid[c] = pend_q && (pcore_q == IW'(c));
      wgd_core_slot slot_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .kick     (kick),
        .kick_cap (kick_cap),
        .ceil_q   (ceil_q),
        .lim_wr   (lim_wr[c]),
        .lim_val  (lim_val[c*RES_W +: RES_W]),
        .accept   (accept[c]),
        .done     (done_pulse[c]),
        .eligible (eligible[c]),
        .idle     (idle[c])
      );
    end
  endgenerate

  always_comb begin
    kick      = start && !active_q;
    fire      = pend_q && issue_ready[pcore_q];
    kick_ceil = (hw_max == '0) ? res_t'(1) :
                (hw_max > res_t'(MAX_RES)) ? res_t'(MAX_RES) : hw_max;
    kick_cap  = start_cap(kick_ceil);
    can_pick  = active_q && !pend_q && (next_q != total_q) && pick_any;
    drained   = active_q && !pend_q && (next_q == total_q) && (&idle);

    active_d = active_q;
    pend_d   = pend_q;
    kdone_d  = kdone_q;
    total_d  = total_q;
    ceil_d   = ceil_q;
    next_d   = next_q;
    pgid_d   = pgid_q;
    pcore_d  = pcore_q;
    ptr_d    = ptr_q;

    if (kick) begin
      active_d = 1'b1;
      kdone_d  = 1'b0;
      pend_d   = 1'b0;
      total_d  = total_groups;
      ceil_d   = kick_ceil;
      next_d   = '0;
      ptr_d    = '0;
    end else if (drained) begin
      active_d = 1'b0;
      kdone_d  = 1'b1;
    end else if (can_pick) begin
      pend_d  = 1'b1;
      pgid_d  = next_q;
      pcore_d = pick_idx;
      next_d  = next_q + 1'b1;
      ptr_d   = (pick_idx == IW'(NUM_CORES - 1)) ? '0 : pick_idx + 1'b1;
    end else if (fire) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      kdone_q  <= 1'b0;
      total_q  <= '0;
      ceil_q   <= res_t'(1);
      next_q   <= '0;
      pgid_q   <= '0;
      pcore_q  <= '0;
      ptr_q    <= '0;
    end else begin
      active_q <= active_d;
      pend_q   <= pend_d;
      kdone_q  <= kdone_d;
      total_q  <= total_d;
      ceil_q   <= ceil_d;
      next_q   <= next_d;
      pgid_q   <= pgid_d;
      pcore_q  <= pcore_d;
      ptr_q    <= ptr_d;
    end
  end

  assign issue_gid   = pgid_q;
  assign kernel_done = kdone_q;

  assert_offer_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !fire) |=> ($stable(issue_valid) && $stable(issue_gid)));

  assert_gid_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|issue_valid) |-> (issue_gid < total_q));

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    kernel_done |-> (issue_valid == '0));
endmodule

// File: tb/wgd_dispatch_tb_top.sv
module wgd_dispatch_tb_top;
  localparam int C  = 4;
  localparam int GW = 16;
  localparam int RW = wgd_pkg::RES_W;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            start;
  logic [GW-1:0]   total_groups;
  logic [RW-1:0]   hw_max;
  logic [C-1:0]    lim_wr;
  logic [C*RW-1:0] lim_val;
  logic [C-1:0]    done_pulse;
  logic [C-1:0]    issue_ready;
  logic [C-1:0]    issue_valid;
  logic [GW-1:0]   issue_gid;
  logic            kernel_done;

  always #10 clk = ~clk;

  wgd_dispatch #(.NUM_CORES(C), .GID_W(GW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .total_groups(total_groups),
    .hw_max(hw_max), .lim_wr(lim_wr), .lim_val(lim_val), .done_pulse(done_pulse),
    .issue_ready(issue_ready), .issue_valid(issue_valid), .issue_gid(issue_gid),
    .kernel_done(kernel_done)
  );

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  int m_res[C];
  int m_lim[C];
  int m_limp[C];
  int m_max, m_total, m_issued, m_ptr;
  bit seen;
  int s_core, s_gid;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
    end
  end

  function automatic int cap_of(input int n);
    int e, h;
    e = (n < 1) ? 1 : ((n > 8) ? 8 : n);
    h = e / 2;
    return (h < 1) ? 1 : h;
  endfunction

  function automatic int exp_core();
    for (int k = 0; k < C; k++) begin
      int c;
      c = (m_ptr + k) % C;
      if (m_res[c] < m_lim[c]) return c;
    end
    return -1;
  endfunction

  function automatic bit drained();
    bit z;
    z = (m_issued == m_total) && !seen;
    for (int c = 0; c < C; c++) if (m_res[c] != 0) z = 0;
    return z;
  endfunction

  function automatic int spread();
    int lo, hi;
    lo = m_res[0]; hi = m_res[0];
    for (int c = 1; c < C; c++) begin
      if (m_res[c] < lo) lo = m_res[c];
      if (m_res[c] > hi) hi = m_res[c];
    end
    return hi - lo;
  endfunction

  // One clock: observe at the negedge, drive, model the edge, advance.
  task automatic cyc(input logic [C-1:0] rdy, input logic [C-1:0] dn, input bit strict);
    int oc;
    oc = -1;
    for (int c = 0; c < C; c++) if (issue_valid[c]) oc = c;
    chk($countones(issue_valid) <= 1, "R6 single offer", $countones(issue_valid), 1);
    if (oc >= 0) begin
      if (!seen) begin
        chk(int'(issue_gid) == m_issued, "R3 gid order", int'(issue_gid), m_issued);
        if (strict)
          chk(oc == exp_core(), "R5 rotating pick", oc, exp_core());
        else
          chk(m_res[oc] < ((m_lim[oc] > m_limp[oc]) ? m_lim[oc] : m_limp[oc]),
              "R4 offer only below cap", m_res[oc], m_lim[oc]);
        seen = 1; s_core = oc; s_gid = int'(issue_gid);
      end else begin
        chk(oc == s_core && int'(issue_gid) == s_gid, "R6 offer stable",
            int'(issue_gid), s_gid);
      end
    end
    if (kernel_done) chk(drained(), "R9 done only when drained", 0, 1);
    issue_ready = rdy;
    for (int c = 0; c < C; c++) done_pulse[c] = dn[c] && (m_res[c] > 0);
    for (int c = 0; c < C; c++) if (done_pulse[c]) m_res[c]--;
    if (oc >= 0 && rdy[oc]) begin
      m_res[oc]++;
      m_issued++;
      m_ptr = (oc + 1) % C;
      seen = 0;
    end
    @(posedge clk);
    @(negedge clk);
    lim_wr = '0;
    done_pulse = '0;
  endtask

  task automatic set_lim(input int c, input int v);
    lim_wr[c] = 1'b1;
    lim_val[c*RW +: RW] = RW'(v);
    if (v >= 1 && v <= m_max) begin
      m_limp[c] = m_lim[c];
      m_lim[c] = v;
    end
  endtask

  task automatic kick(input int tot, input int n);
    start = 1'b1;
    total_groups = GW'(tot);
    hw_max = RW'(n);
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    m_max = (n < 1) ? 1 : ((n > 8) ? 8 : n);
    m_total = tot; m_issued = 0; m_ptr = 0; seen = 0;
    for (int c = 0; c < C; c++) begin
      m_res[c] = 0; m_lim[c] = cap_of(n); m_limp[c] = cap_of(n);
    end
    chk(kernel_done == 1'b0, "R9 cleared by start", kernel_done, 0);
  endtask

  task automatic drain(input bit lims);
    for (int i = 0; i < 4000; i++) begin
      logic [C-1:0] dn;
      if (kernel_done) break;
      for (int c = 0; c < C; c++) dn[c] = ($urandom % 4) == 0;
      if (lims && ($urandom % 16) == 0) set_lim($urandom % C, $urandom % 10);
      cyc(C'($urandom), dn, 0);
    end
    chk(kernel_done == 1'b1, "R9 kernel done reached", kernel_done, 1);
    chk(m_issued == m_total, "R3 every group accepted once", m_issued, m_total);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; start = 1'b0; total_groups = '0; hw_max = '0;
    lim_wr = '0; lim_val = '0; done_pulse = '0; issue_ready = '0;
    m_max = 1; m_total = 0; m_issued = 0; m_ptr = 0; seen = 0;
    for (int c = 0; c < C; c++) begin m_res[c] = 0; m_lim[c] = 1; m_limp[c] = 1; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(issue_valid == '0, "R1 no offer after reset", int'(issue_valid), 0);
    chk(kernel_done == 1'b0, "R1 done low after reset", kernel_done, 0);
    repeat (3) @(negedge clk);
    chk(issue_valid == '0, "R1 idle without start", int'(issue_valid), 0);

    // Fill pass: ceiling 8 gives cap 4 on each core.
    kick(20, 8);
    for (int i = 0; i < 40; i++) begin
      cyc('1, '0, 1);
      chk(spread() <= 1, "R5 balanced fill", spread(), 1);
    end
    chk(m_issued == 16, "R2 cap is half ceiling", m_issued, 16);
    for (int c = 0; c < C; c++) chk(m_res[c] == 4, "R2 per-core cap", m_res[c], 4);
    chk(issue_valid == '0, "R4 stall at cap", int'(issue_valid), 0);

    // Start while running must be ignored; then refill core 2.
    start = 1'b1; total_groups = GW'(2); hw_max = RW'(1);
    cyc('0, '0, 1);
    start = 1'b0;
    cyc('1, 4'b0100, 1);
    for (int i = 0; i < 6; i++) cyc('1, '0, 1);
    chk(m_issued == 17 && m_res[2] == 4, "R2 start ignored while active", m_issued, 17);

    // Out-of-range cap writes are ignored.
    set_lim(0, 9);
    for (int i = 0; i < 6; i++) cyc('1, '0, 1);
    chk(issue_valid == '0 && m_issued == 17, "R7 cap above ceiling ignored", m_issued, 17);
    set_lim(0, 0);
    for (int i = 0; i < 6; i++) cyc('1, '0, 1);
    chk(issue_valid == '0 && m_issued == 17, "R7 zero cap ignored", m_issued, 17);
    set_lim(0, 5);
    for (int i = 0; i < 6; i++) cyc('1, '0, 1);
    chk(m_res[0] == 5 && m_issued == 18, "R7 valid cap raises residency", m_res[0], 5);

    // Lowered cap: no eviction, no refill until below the new cap.
    set_lim(1, 2);
    cyc('1, '0, 1);
    cyc('1, 4'b0010, 1);
    for (int i = 0; i < 4; i++) cyc('1, '0, 1);
    chk(m_issued == 18, "R8 no refill above lowered cap", m_issued, 18);
    cyc('1, 4'b0010, 1);
    for (int i = 0; i < 4; i++) cyc('1, '0, 1);
    chk(m_issued == 18, "R8 no refill at lowered cap", m_issued, 18);
    cyc('1, 4'b0010, 1);
    for (int i = 0; i < 4; i++) cyc('1, '0, 1);
    chk(m_issued == 19 && m_res[1] == 2, "R8 refill below lowered cap", m_res[1], 2);
    drain(0);

    // Ceiling 1: cap rounds up to 1, three groups on three cores.
    kick(3, 1);
    for (int i = 0; i < 12; i++) cyc('1, '0, 1);
    chk(m_res[0] == 1 && m_res[1] == 1 && m_res[2] == 1 && m_res[3] == 0,
        "R2 minimum cap one", m_res[3], 0);
    chk(kernel_done == 1'b0, "R9 not done with groups resident", kernel_done, 0);
    drain(0);

    // Empty kernel.
    kick(0, 4);
    for (int i = 0; i < 3; i++) cyc('1, '0, 1);
    chk(kernel_done == 1'b1 && m_issued == 0, "R9 empty kernel completes", kernel_done, 1);

    // Random kernels with random ready, completions and cap writes.
    for (int k = 0; k < 6; k++) begin
      kick(10 + ($urandom % 40), 1 + ($urandom % 8));
      drain(1);
      chk(m_res[0] <= m_max, "R10 residency within ceiling", m_res[0], m_max);
    end

    $display("test done: total=%0d bad=%0d", checks, fails);
    $finish;
  end
endmodule